// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block is one registered pipeline stage of a floating-point result path. It takes an unpacked mantissa whose two least significant bits are a guard bit and a round bit. It also takes a separate sticky bit, the sign of the value and a 2-bit rounding-mode code. It drops the guard and round bits and, where the mode calls for it, adds one unit in the last retained place. On the next clock edge it presents the rounded mantissa, a flag that says an increment happened, an inexact flag, and a decision on how the consumer should saturate if the exponent later overflows.

The output mantissa is one bit wider than the retained field. A carry out of the retained field therefore shows up as a set top bit: a significand of 2.0 comes out as a set top bit with all other bits clear. The stage does not correct that value. Adjusting the exponent, renormalising and packing are left to the consumer, which uses the rounded-up flag to decide whether such a correction is needed.

Mode codes: 0 selects round to nearest with ties to even, 1 selects toward zero, 2 selects toward plus infinity and 3 selects toward minus infinity.

Top module: `mant_rounder`

## Requirements
- R1: While `rst_n` is low, every output is zero after each rising clock edge.
- R2: Outputs change only at a rising clock edge. Each one reflects the inputs sampled at the previous edge, so the latency is one cycle.
- R3: `mant_out` equals `mant_in` shifted right by two places, zero-extended by one bit, plus one when `rnd_up` is set. The shift happens whether or not rounding occurs.
- R4: When guard (`mant_in[1]`), round (`mant_in[0]`) and `sticky_in` are all zero, `rnd_up` and `inexact` are both 0.
- R5: When any of guard, round or sticky is set, `inexact` is 1.
- R6: In mode 0, an increment happens exactly when guard is set and at least one of these holds: round is set, sticky is set, or `mant_in[2]` (the retained LSB) is 1.
- R7: In mode 1, no increment ever happens.
- R8: In mode 2, an increment happens exactly when the value is inexact and `sign_in` is 0. In mode 3, it happens exactly when the value is inexact and `sign_in` is 1.
- R9: The increment carries through the whole retained field. An all-ones retained field that is incremented gives `mant_out` with only its top bit set, and `rnd_up` is 1.
- R10: `ovf_to_inf` is 1 in mode 0 and 0 in mode 1. In mode 2 it equals the inverse of `sign_in`, and in mode 3 it equals `sign_in`.
- R11: `rnd_up` is 1 exactly when an increment was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mant_in | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_in | input | 1 | OR of all bits below the round bit |
| sign_in | input | 1 | Sign of the value, 1 for negative |
| mode_in | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_out | output | MANT_W-1 | Rounded mantissa with a carry bit on top |
| rnd_up | output | 1 | An increment was applied |
| inexact | output | 1 | Discarded bits were non-zero |
| ovf_to_inf | output | 1 | Overflow should saturate to infinity rather than the largest finite value |

## Verification
The assertions assume every input is a defined 0 or 1 at each rising edge once reset is released. They also assume that all four mode codes are legal, so no code is ever treated as reserved. The stimulus drives every input on the falling edge, from a fixed-seed generator or from directed tables, and never leaves a bit undriven. As a result, the cycle after each edge always compares against a fully known input set. The directed part walks every guard, round and sticky combination against both signs, both LSB parities and all four modes, and also includes the all-ones carry case.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic [MANT_W-2:0] mant_out,
  output logic              rnd_up,
  output logic              inexact,
  output logic              ovf_to_inf
);
  localparam int RW = MANT_W - 2;

  logic [RW-1:0] keep;
  logic          grd, rnd, lost, inc, to_inf;
  logic [RW:0]   sum;

  assign keep = mant_in[MANT_W-1:2];
  assign grd  = mant_in[1];
  assign rnd  = mant_in[0];
  assign lost = grd | rnd | sticky_in;

  always_comb begin
    unique case (mode_in)
      2'd0: begin
        inc    = grd & (rnd | sticky_in | keep[0]);
        to_inf = 1'b1;
      end
      2'd1: begin
        inc    = 1'b0;
        to_inf = 1'b0;
      end
      2'd2: begin
        inc    = lost & ~sign_in;
        to_inf = ~sign_in;
      end
      default: begin
        inc    = lost & sign_in;
        to_inf = sign_in;
      end
    endcase
  end

  assign sum = {1'b0, keep} + {{RW{1'b0}}, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mant_out   <= '0;
      rnd_up     <= 1'b0;
      inexact    <= 1'b0;
      ovf_to_inf <= 1'b0;
    end else begin
      mant_out   <= sum;
      rnd_up     <= inc;
      inexact    <= lost;
      ovf_to_inf <= to_inf;
    end
  end
endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
  parameter int MANT_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MANT_W-1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic [MANT_W-2:0] mant_out,
  input logic              rnd_up,
  input logic              inexact,
  input logic              ovf_to_inf
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  logic [2:0] grs;
  assign grs = {mant_in[1:0], sticky_in};

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (mant_out == '0 && !rnd_up && !inexact && !ovf_to_inf));

  p_mant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> mant_out == ({1'b0, $past(mant_in[MANT_W-1:2])} + (MANT_W-1)'(rnd_up)));

  p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(grs) == 3'b000) |-> (!rnd_up && !inexact));

  p_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(grs) != 3'b000) |-> inexact);

  p_no_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode_in) == 2'd1) |-> !rnd_up);

  p_pos_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode_in) == 2'd3 && !$past(sign_in)) |-> !rnd_up);

  p_neg_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode_in) == 2'd2 && $past(sign_in)) |-> !rnd_up);

  p_inf_near_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode_in) == 2'd0) |-> ovf_to_inf);

  p_inf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(mode_in) == 2'd1) |-> !ovf_to_inf);

  p_up_exact_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_up |-> inexact);
endmodule

bind mant_rounder mant_rounder_chk #(.MANT_W(MANT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
  .sign_in(sign_in), .mode_in(mode_in), .mant_out(mant_out),
  .rnd_up(rnd_up), .inexact(inexact), .ovf_to_inf(ovf_to_inf)
);

// File: tb/tb_mant_rounder.sv
module tb_mant_rounder;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mant_in = '0;
  logic         sticky_in = 1'b0;
  logic         sign_in = 1'b0;
  logic [1:0]   mode_in = 2'd0;
  logic [W-2:0] mant_out;
  logic         rnd_up, inexact, ovf_to_inf;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mant_rounder #(.MANT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
    .sign_in(sign_in), .mode_in(mode_in), .mant_out(mant_out),
    .rnd_up(rnd_up), .inexact(inexact), .ovf_to_inf(ovf_to_inf)
  );

  function automatic bit want_up(logic [W-1:0] m, bit s, bit neg, logic [1:0] md);
    int tail;
    tail = {m[1:0], s};
    case (md)
      2'd0:    return (tail > 4) || (tail == 4 && m[2]);
      2'd1:    return 1'b0;
      2'd2:    return (tail != 0) && !neg;
      default: return (tail != 0) && neg;
    endcase
  endfunction

  function automatic bit want_inf(bit neg, logic [1:0] md);
    if (md == 2'd0) return 1'b1;
    if (md == 2'd1) return 1'b0;
    if (md == 2'd2) return !neg;
    return neg;
  endfunction

  task automatic apply(logic [W-1:0] m, bit s, bit neg, logic [1:0] md);
    bit           eu, ei, ef;
    logic [W-2:0] em;
    @(negedge clk);
    mant_in = m; sticky_in = s; sign_in = neg; mode_in = md;
    eu = want_up(m, s, neg, md);
    ei = (m[1:0] != 2'b00) || s;
    ef = want_inf(neg, md);
    em = (W-1)'(m >> 2) + (W-1)'(eu);
    @(posedge clk);
    #1;
    checks++;
    if (mant_out !== em || rnd_up !== eu || inexact !== ei || ovf_to_inf !== ef) begin
      fails++;
      if (mant_out !== em)
        $display("FAIL R3/R9 mant_out act=%h exp=%h (mode %0d)", mant_out, em, md);
      if (rnd_up !== eu)
        $display("FAIL R6/R7/R8/R11 rnd_up act=%b exp=%b (mode %0d sign %0d)", rnd_up, eu, md, neg);
      if (inexact !== ei)
        $display("FAIL R4/R5 inexact act=%b exp=%b", inexact, ei);
      if (ovf_to_inf !== ef)
        $display("FAIL R10 ovf_to_inf act=%b exp=%b (mode %0d)", ovf_to_inf, ef, md);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [W-1:0] m;
    seed = 32'd1234;
    void'($urandom(seed));
    mant_in = {W{1'b1}}; sticky_in = 1'b1; sign_in = 1'b1; mode_in = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mant_out !== '0 || rnd_up !== 1'b0 || inexact !== 1'b0 || ovf_to_inf !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs act=%h/%b/%b/%b exp=0/0/0/0",
               mant_out, rnd_up, inexact, ovf_to_inf);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R4 R5 R6 R7 R8 R10: every tail pattern, both parities, signs, modes
    for (int md = 0; md < 4; md++)
      for (int neg = 0; neg < 2; neg++)
        for (int par = 0; par < 2; par++)
          for (int t = 0; t < 8; t++) begin
            m = {{(W-3){1'b0}}, 1'b0, 2'b00} | (W'(3'b101) << 3);
            m[2] = par[0];
            m[1:0] = t[2:1];
            apply(m, t[0], neg[0], md[1:0]);
          end

    // R9: full carry chain to 2.0
    for (int md = 0; md < 4; md++)
      for (int neg = 0; neg < 2; neg++)
        apply({W{1'b1}}, 1'b1, neg[0], md[1:0]);
    apply({{(W-2){1'b1}}, 2'b10}, 1'b0, 1'b0, 2'd0);
    apply({{(W-2){1'b1}}, 2'b00}, 1'b0, 1'b0, 2'd2);

    // R3: random mix
    for (int i = 0; i < 3000; i++)
      apply(W'($urandom()), 1'($urandom()), 1'($urandom()), 2'($urandom()));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule